// File: doc/BRIEF.md
# Sample Timing Programming Sequencer

This block turns a speed-mode request into a programmed set of card-interface timing registers. Given a speed-mode code, a select between an SD and an SDIO controller, and optionally a sample phase chosen by the caller, it looks up per-mode timing parameters in a built-in table. From these it works out a drive phase, a sample delay, the sample phase, a shift-enable flag and a delay-use flag.

It then runs a fixed write sequence on a simple register write port. First it stops the interface clock. It waits a short settle time. It then writes the extended timing word and the shift-enable register. Last, it restarts the clock with its divider and delay-use setting. It holds off for a long settle period before pulsing done.

A typical use is once per speed change, or once per candidate phase during a phase sweep. The caller issues a one-cycle start and waits for done before sending the next request.

Top module: `tap_timing_seq`

## Requirements
- R1: After reset, busy, wr_en and done are all 0.
- R2: When phase_force is 0, the sample phase is floor((max + min) / 2) of the selected table entry.
- R3: When phase_force is 1, the sample phase is phase_value unchanged.
- R4: The delay-use flag is 1 only in speed mode 6 and only for sample phases 11 to 14 inclusive.
- R5: The shift-enable flag is 1 only in speed modes 5 and 6 and only for sample phases 4 to 12 inclusive. The shift register write carries this flag in bit 0, with all other bits 0.
- R6: The extended timing word holds the sample phase in bits 20:16, the drive phase in bits 25:21 and the sample delay in bits 30:26, with all other bits 0.
- R7: A request produces exactly four writes in this order: clock control (wr_addr 0) with data 0, extended timing (wr_addr 1), shift enable (wr_addr 2), clock control (wr_addr 0). Each write is a single-cycle wr_en pulse.
- R8: The extended timing write comes SHORT_WAIT+1 cycles after the clearing write. The shift write and the final clock write each follow the previous write by one cycle.
- R9: done pulses for one cycle, LONG_WAIT+1 cycles after the final clock write. busy is 0 in the cycle after done.
- R10: A start that arrives while busy is 1 is ignored. It causes no extra writes and does not change the data of the sequence in progress.
- R11: SD table entries {drive, delay, max, min} by mode:
  - mode 0: 7,0,15,15
  - mode 1: 6,0,4,4
  - mode 2: 6,0,3,3
  - mode 3: 6,0,15,15
  - mode 4: 6,0,2,2
  - mode 5: 4,0,11,0
  - mode 6: 6,4,15,0

  SDIO table entries by mode:
  - mode 0: 7,0,15,15
  - mode 2: 6,0,15,15
  - mode 3: 6,0,15,15
  - mode 4: 6,0,0,0
  - mode 5: 4,0,12,0
  - mode 6: 5,4,15,0

  Every other mode, including SDIO mode 1 and modes 7 to 15, is all zeros.
- R12: The final clock control write holds 7 in bits 11:8, the delay-use flag in bit 13, 1 in bit 16, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request, taken only when idle |
| sdio_sel | input | 1 | 0 selects the SD table, 1 selects the SDIO table |
| speed_mode | input | 4 | Speed-mode code |
| phase_force | input | 1 | 1 uses phase_value instead of the table midpoint |
| phase_value | input | 5 | Requested sample phase |
| busy | output | 1 | Sequence in progress |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 2 | 0 clock control, 1 extended timing, 2 shift enable |
| wr_data | output | 32 | Register write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start that arrives while a sequence is in flight. It must leave the remaining writes untouched and must not queue a second sequence. The stimulus fires a second start carrying a different mode and phase in the middle of the short wait. The scoreboard then still expects only the original four writes and one done, and it flags any write seen with an empty queue. The phase window edges (3, 4, 11, 12, 13, 14, 15) are reached by forcing the phase in modes 5 and 6 and in a mode outside both windows.

// File: rtl/tap_timing_seq.sv
module tap_timing_seq #(
  parameter int SHORT_WAIT = 500,
  parameter int LONG_WAIT  = 100000,
  localparam int CW = $clog2((LONG_WAIT > SHORT_WAIT ? LONG_WAIT : SHORT_WAIT) + 1) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sdio_sel,
  input  logic [3:0]  speed_mode,
  input  logic        phase_force,
  input  logic [4:0]  phase_value,
  output logic        busy,
  output logic        wr_en,
  output logic [1:0]  wr_addr,
  output logic [31:0] wr_data,
  output logic        done
);

  localparam logic [1:0] A_CLK = 2'd0;
  localparam logic [1:0] A_EXT = 2'd1;
  localparam logic [1:0] A_SHF = 2'd2;
  localparam logic [3:0] CLK_DIV = 4'd7;

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_WS, S_EXT, S_SHF, S_CLK, S_WL, S_DONE} st_t;
  st_t st;

  function automatic logic [19:0] tbl(input logic sdio, input logic [3:0] m);
    logic [19:0] r;
    r = '0;
    case ({sdio, m})
      5'h00, 5'h10: r = {5'd7, 5'd0, 5'd15, 5'd15};
      5'h01:        r = {5'd6, 5'd0, 5'd4,  5'd4 };
      5'h02:        r = {5'd6, 5'd0, 5'd3,  5'd3 };
      5'h03:        r = {5'd6, 5'd0, 5'd15, 5'd15};
      5'h04:        r = {5'd6, 5'd0, 5'd2,  5'd2 };
      5'h05:        r = {5'd4, 5'd0, 5'd11, 5'd0 };
      5'h06:        r = {5'd6, 5'd4, 5'd15, 5'd0 };
      5'h12, 5'h13: r = {5'd6, 5'd0, 5'd15, 5'd15};
      5'h14:        r = {5'd6, 5'd0, 5'd0,  5'd0 };
      5'h15:        r = {5'd4, 5'd0, 5'd12, 5'd0 };
      5'h16:        r = {5'd5, 5'd4, 15 == 15 ? 5'd15 : 5'd0, 5'd0};
      default:      r = '0;
    endcase
    return r;
  endfunction

  logic [19:0] ent;
  logic [5:0]  psum;
  logic [4:0]  ph;
  logic        shf_n, use_n;

  assign ent   = tbl(sdio_sel, speed_mode);
  assign psum  = {1'b0, ent[9:5]} + {1'b0, ent[4:0]};
  assign ph    = phase_force ? phase_value : psum[5:1];
  assign shf_n = (speed_mode == 4'd5 || speed_mode == 4'd6) && ph >= 5'd4 && ph <= 5'd12;
  assign use_n = (speed_mode == 4'd6) && ph >= 5'd11 && ph <= 5'd14;

  logic [31:0]   ext_q;
  logic          shf_q, use_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ext_q <= '0;
      shf_q <= 1'b0;
      use_q <= 1'b0;
      cnt   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ext_q <= {1'b0, ent[14:10], ent[19:15], ph, 16'h0};
          shf_q <= shf_n;
          use_q <= use_n;
          st    <= S_CLR;
        end
        S_CLR: begin
          cnt <= CW'(SHORT_WAIT - 1);
          st  <= S_WS;
        end
        S_WS: if (cnt == '0) st <= S_EXT; else cnt <= cnt - 1'b1;
        S_EXT: st <= S_SHF;
        S_SHF: st <= S_CLK;
        S_CLK: begin
          cnt <= CW'(LONG_WAIT - 1);
          st  <= S_WL;
        end
        S_WL: if (cnt == '0) st <= S_DONE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st != S_IDLE);
  assign done  = (st == S_DONE);
  assign wr_en = (st == S_CLR) || (st == S_EXT) || (st == S_SHF) || (st == S_CLK);

  always_comb begin
    wr_addr = A_CLK;
    wr_data = '0;
    case (st)
      S_EXT: begin wr_addr = A_EXT; wr_data = ext_q; end
      S_SHF: begin wr_addr = A_SHF; wr_data = {31'h0, shf_q}; end
      S_CLK: wr_data = {15'h0, 1'b1, 2'b00, use_q, 1'b0, CLK_DIV, 8'h00};
      default: ;
    endcase
  end

endmodule

module tap_timing_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        done
);
  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy); // R7
  AST_EXT_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> (wr_en && wr_addr == 2'd2)); // R7
  AST_SHIFT_THEN_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |=> (wr_en && wr_addr == 2'd0 && wr_data[16])); // R12
  AST_SHIFT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |-> (wr_data[31:1] == 31'h0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R9
  AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !wr_en); // R9
endmodule

bind tap_timing_seq tap_timing_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
);

// File: tb/tap_timing_seq_bench.sv
module tap_timing_seq_bench;
  localparam int SW = 3;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sdio_sel = 1'b0, phase_force = 1'b0;
  logic [3:0] speed_mode = '0;
  logic [4:0] phase_value = '0;
  logic busy, wr_en, done;
  logic [1:0] wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  tap_timing_seq #(.SHORT_WAIT(SW), .LONG_WAIT(LW)) u_tap_timing_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sdio_sel(sdio_sel),
    .speed_mode(speed_mode), .phase_force(phase_force), .phase_value(phase_value),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  typedef struct {
    bit          is_done;
    logic [1:0]  addr;
    logic [31:0] data;
    int          gap;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  int cyc = 0, last_ev = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model of the table: R11
  function automatic void model(input bit sd, input int m, output int drv, output int dly, output int mx, output int mn);
    drv = 0; dly = 0; mx = 0; mn = 0;
    if (m == 0) begin drv = 7; mx = 15; mn = 15; end
    else if (!sd) begin
      if (m == 1) begin drv = 6; mx = 4;  mn = 4;  end
      if (m == 2) begin drv = 6; mx = 3;  mn = 3;  end
      if (m == 3) begin drv = 6; mx = 15; mn = 15; end
      if (m == 4) begin drv = 6; mx = 2;  mn = 2;  end
      if (m == 5) begin drv = 4; mx = 11; end
      if (m == 6) begin drv = 6; dly = 4; mx = 15; end
    end else begin
      if (m == 2 || m == 3) begin drv = 6; mx = 15; mn = 15; end
      if (m == 4) drv = 6;
      if (m == 5) begin drv = 4; mx = 12; end
      if (m == 6) begin drv = 5; dly = 4; mx = 15; end
    end
  endfunction

  task automatic push(input bit d, input logic [1:0] a, input logic [31:0] v, input int g, input string t);
    item_t it;
    it.is_done = d; it.addr = a; it.data = v; it.gap = g; it.tag = t;
    q.push_back(it);
  endtask

  task automatic run(input bit sd, input int m, input bit f, input int pv, input string tag, input bit poke);
    int drv, dly, mx, mn, ph;
    bit sh, us;
    model(sd, m, drv, dly, mx, mn);
    ph = f ? pv : (mx + mn) / 2;                      // R2 midpoint, R3 forced
    sh = (m == 5 || m == 6) && ph >= 4 && ph <= 12;   // R5
    us = (m == 6) && ph >= 11 && ph <= 14;            // R4
    push(0, 2'd0, 32'h0, -1, {tag, " R7 clear"});
    push(0, 2'd1, (32'(dly) << 26) | (32'(drv) << 21) | (32'(ph) << 16), SW + 1, {tag, " R6 R11 R8 ext"});
    push(0, 2'd2, 32'(sh), 1, {tag, " R5 shift"});
    push(0, 2'd0, (32'd7 << 8) | (32'(us) << 13) | (32'd1 << 16), 1, {tag, " R4 R12 clk"});
    push(1, 2'd0, 32'h0, LW + 1, {tag, " R9 done"});
    @(negedge clk);
    sdio_sel = sd; speed_mode = 4'(m); phase_force = f; phase_value = 5'(pv); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      // R10: second request mid-sequence with different settings
      sdio_sel = ~sd; speed_mode = 4'd6; phase_force = 1'b1; phase_value = 5'd12; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, {tag, " R9 idle after done"}, 32'(busy), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && (wr_en || done)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected activity", {wr_addr, wr_data[29:0]}, 32'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(done == it.is_done && (it.is_done || (wr_addr == it.addr && wr_data == it.data)),
            it.tag, it.is_done ? 32'(done) : wr_data, it.is_done ? 32'h1 : it.data);
        if (it.gap >= 0) chk(cyc - last_ev == it.gap, {it.tag, " R8 spacing"}, 32'(cyc - last_ev), 32'(it.gap));
      end
      last_ev = cyc;
    end
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && wr_en == 0 && done == 0, "R1 reset outputs", {busy, wr_en, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && wr_en == 0 && done == 0, "R1 idle after reset", {busy, wr_en, done}, 32'h0);
    run(0, 0, 0, 0,  "R2 sd legacy", 0);
    run(0, 1, 0, 0,  "R2 sd mode1", 0);
    run(0, 5, 0, 0,  "R2 sd mode5", 0);
    run(0, 6, 0, 0,  "R2 sd mode6", 0);
    run(0, 6, 1, 11, "R3 R4 ph11", 0);
    run(0, 6, 1, 13, "R3 R4 ph13", 0);
    run(0, 6, 1, 14, "R4 ph14", 0);
    run(0, 6, 1, 15, "R4 ph15", 0);
    run(0, 6, 1, 12, "R5 ph12", 0);
    run(0, 6, 1, 3,  "R5 ph3", 0);
    run(0, 5, 1, 4,  "R5 mode5 ph4", 0);
    run(0, 5, 1, 13, "R5 R4 mode5 ph13", 0);
    run(0, 2, 1, 8,  "R5 mode2 ph8", 0);
    run(1, 6, 0, 0,  "R11 sdio mode6", 0);
    run(1, 5, 0, 0,  "R11 sdio mode5", 0);
    run(1, 4, 0, 0,  "R11 sdio mode4", 0);
    run(1, 1, 0, 0,  "R11 sdio zero mode1", 0);
    run(0, 12, 0, 0, "R11 zero mode12", 0);
    run(0, 3, 1, 31, "R3 ph31", 0);
    run(0, 0, 0, 0,  "R10 busy start", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule